// File: doc/BRIEF.md
# Bank Conflict Serializer with Read Broadcast

This block sits in front of a multi-bank scratchpad. Each of its lanes presents a byte address, and the block splits every address into a bank number and a word position inside that bank. It then decides which lanes can reach their banks in the current cycle without two lanes landing on the same bank. A request whose lanes all target different banks is issued in a single cycle. A request with clashes is spread over several consecutive issue cycles, and the block holds off new requests until the last of those cycles.

Lane priority is fixed: the lowest-numbered pending lane always wins. During a read, every pending lane that addresses exactly the same word as the winning lane rides along in the same cycle as a broadcast, because those lanes need only one bank access. Stores never merge. Each cycle the block emits the mask of lanes served, the per-lane bank number and word position, a flag marking the final issue cycle of a request, and a ready indication for the upstream issue logic.

Top module: `bank_serializer`

## Requirements
- R1: Address fields for the default configuration: bits 1:0 select a byte and are ignored, bits 3:2 give the bank number and bits 9:4 give the word position. Lane k's fields appear at bank_idx_o[2k+1:2k] and bank_off_o[6k+5:6k].
- R2: A request is taken only in a cycle where start_i and ready_o are both high. With start_i low, or with an all-zero lane mask, no lane is served, last_o stays low and ready_o stays high.
- R3: In every issue cycle the lowest-numbered pending lane is served. A pending lane whose bank matches that of a lower-numbered pending lane is held back, unless R4 applies.
- R4: On a read (store_i low), every pending lane with the same bank and word position as the lowest pending lane is served in the same cycle as that lane.
- R5: On a store, at most one lane per bank is served in any cycle, even when several lanes address the same word.
- R6: When lanes remain after an issue cycle, ready_o goes low on the next cycle. While ready_o is low, the block ignores start_i, store_i, lane_mask_i and addr_i, and it replays the bank numbers and word positions of the stored request.
- R7: When n lanes hit one bank at different words, the request takes exactly n consecutive issue cycles, with the lanes served in ascending order. ready_o is high again on the cycle after the final issue cycle.
- R8: last_o is high only in the final issue cycle of a request with a non-zero lane mask.
- R9: A request with no bank clash is served completely in its first cycle with ready_o still high, so such requests can be accepted on every clock.
- R10: During and right after reset, ready_o is high, and no lane is served while start_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request presented this cycle |
| store_i | input | 1 | 1 = store request, 0 = read request |
| lane_mask_i | input | NUM_LANES | Lanes taking part in the request |
| addr_i | input | NUM_LANES*ADDR_W | Byte address per lane, lane k at bits [k*ADDR_W +: ADDR_W] |
| ready_o | output | 1 | A new request can be taken |
| served_o | output | NUM_LANES | Lanes issued to their banks this cycle |
| bank_idx_o | output | NUM_LANES*BANK_W | Bank number per lane |
| bank_off_o | output | NUM_LANES*OFF_W | Word position inside the bank, per lane |
| last_o | output | 1 | Final issue cycle of the current request |

## Verification
The hardest behaviour to reach from the ports is the replay during a multi-cycle request, where partial broadcasts and leftover clashes appear together while the inputs change underneath. The stimulus sweeps every assignment of banks to the four lanes, every lane mask and both operation types, with two sets of word positions. In one set all words are equal, so broadcast merges as far as it can. In the other set, words differ between odd and even lanes. During every busy cycle the bench drives inverted addresses, an inverted mask and the opposite operation, so any leak of fresh inputs changes the served lanes or the replayed fields.

// File: rtl/bank_ser_pkg.sv
package bank_ser_pkg;
  typedef enum logic {
    ST_READY = 1'b0,
    ST_BUSY  = 1'b1
  } issue_state_e;
endpackage

// File: rtl/bank_addr_map.sv
module bank_addr_map #(
  parameter int unsigned NUM_LANES  = 4,
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned BANK_DEPTH = 64,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned BYTE_W = $clog2(WORD_BYTES),
  localparam int unsigned BANK_W = $clog2(NUM_BANKS),
  localparam int unsigned OFF_W  = $clog2(BANK_DEPTH),
  localparam int unsigned ADDR_W = BYTE_W + BANK_W + OFF_W
) (
  input  logic [NUM_LANES*ADDR_W-1:0] addr_i,
  output logic [NUM_LANES*BANK_W-1:0] bank_o,
  output logic [NUM_LANES*OFF_W-1:0]  off_o
);
  // cyclic mapping: consecutive words walk across the banks
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign bank_o[l*BANK_W +: BANK_W] = addr_i[l*ADDR_W + BYTE_W +: BANK_W];
    assign off_o[l*OFF_W +: OFF_W]    = addr_i[l*ADDR_W + BYTE_W + BANK_W +: OFF_W];
    if (BYTE_W > 0) begin : g_byte
      logic [BYTE_W-1:0] unused_byte;
      assign unused_byte = addr_i[l*ADDR_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/bank_conflict_logic.sv
module bank_conflict_logic #(
  parameter int unsigned NUM_LANES  = 4,
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned BANK_DEPTH = 64,
  localparam int unsigned BANK_W = $clog2(NUM_BANKS),
  localparam int unsigned OFF_W  = $clog2(BANK_DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_LANES-1:0]        pending_i,
  input  logic [NUM_LANES*BANK_W-1:0] bank_i,
  input  logic [NUM_LANES*OFF_W-1:0]  off_i,
  input  logic                        store_i,
  output logic [NUM_LANES-1:0]        served_o,
  output logic [NUM_LANES-1:0]        still_o
);
  logic [BANK_W-1:0]    bank [NUM_LANES];
  logic [OFF_W-1:0]     off  [NUM_LANES];
  logic [NUM_LANES-1:0] clash, bcast;
  logic [BANK_W-1:0]    top_bank;
  logic [OFF_W-1:0]     top_off;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_unpack
    assign bank[l] = bank_i[l*BANK_W +: BANK_W];
    assign off[l]  = off_i[l*OFF_W +: OFF_W];
  end

  // broadcast word = word of the lowest pending lane
  always_comb begin
    top_bank = '0;
    top_off  = '0;
    for (int l = NUM_LANES - 1; l >= 0; l--) begin
      if (pending_i[l]) begin
        top_bank = bank[l];
        top_off  = off[l];
      end
    end
  end

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_decide
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < j; i++) begin
        if (pending_i[i] && (bank[i] == bank[j])) hit = 1'b1;
      end
    end
    assign clash[j] = hit;
    assign bcast[j] = !store_i && (bank[j] == top_bank) && (off[j] == top_off);
  end

  assign served_o = pending_i & (bcast | ~clash);
  assign still_o  = pending_i & ~served_o;

  // R3: any pending work always makes progress
  a_r3_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pending_i) |-> (|served_o));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    logic [NUM_LANES-1:0] in_bank;
    always_comb begin
      for (int l = 0; l < NUM_LANES; l++) in_bank[l] = (bank[l] == BANK_W'(b));
    end
    // R5: stores never double up on a bank
    a_r5_store_one_per_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
      store_i |-> ($countones(served_o & in_bank) <= 1));
  end
endmodule

// File: rtl/bank_issue_ctrl.sv
module bank_issue_ctrl
  import bank_ser_pkg::*;
#(
  parameter int unsigned NUM_LANES = 4,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned OFF_W     = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        store_i,
  input  logic [NUM_LANES-1:0]        mask_i,
  input  logic [NUM_LANES*BANK_W-1:0] bank_i,
  input  logic [NUM_LANES*OFF_W-1:0]  off_i,
  input  logic [NUM_LANES-1:0]        still_i,
  output logic [NUM_LANES-1:0]        pending_o,
  output logic [NUM_LANES*BANK_W-1:0] bank_o,
  output logic [NUM_LANES*OFF_W-1:0]  off_o,
  output logic                        store_o,
  output logic                        ready_o,
  output logic                        last_o
);
  issue_state_e                state_q, state_d;
  logic [NUM_LANES-1:0]        pend_q;
  logic [NUM_LANES*BANK_W-1:0] bank_q;
  logic [NUM_LANES*OFF_W-1:0]  off_q;
  logic                        store_q;
  logic                        capture;

  assign capture = (state_q == ST_READY) && start_i;
  assign state_d = (|still_i) ? ST_BUSY : ST_READY;

  always_comb begin
    if (state_q == ST_READY) begin
      pending_o = start_i ? mask_i : '0;
      bank_o    = bank_i;
      off_o     = off_i;
      store_o   = store_i;
      ready_o   = 1'b1;
      last_o    = !(|still_i) && (|pending_o);
    end else begin
      pending_o = pend_q;
      bank_o    = bank_q;
      off_o     = off_q;
      store_o   = store_q;
      ready_o   = 1'b0;
      last_o    = !(|still_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READY;
      pend_q  <= '0;
      bank_q  <= '0;
      off_q   <= '0;
      store_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= still_i;
      if (capture) begin
        bank_q  <= bank_i;
        off_q   <= off_i;
        store_q <= store_i;
      end
    end
  end

  a_r6_enter_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i && (|still_i)) |=> !ready_o);
  a_r6_replay_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !last_o) |=> ($stable(bank_o) && $stable(off_o) && $stable(store_o)));
  a_r7_pending_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> ((pending_o & ~$past(pending_o)) == '0));
  a_r8_last_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> ready_o);
  a_r9_clean_stays_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !(|still_i)) |=> ready_o);
endmodule

// File: rtl/bank_serializer.sv
module bank_serializer #(
  parameter int unsigned NUM_LANES  = 4,
  parameter int unsigned NUM_BANKS  = 4,
  parameter int unsigned BANK_DEPTH = 64,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned BYTE_W = $clog2(WORD_BYTES),
  localparam int unsigned BANK_W = $clog2(NUM_BANKS),
  localparam int unsigned OFF_W  = $clog2(BANK_DEPTH),
  localparam int unsigned ADDR_W = BYTE_W + BANK_W + OFF_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic                        store_i,
  input  logic [NUM_LANES-1:0]        lane_mask_i,
  input  logic [NUM_LANES*ADDR_W-1:0] addr_i,
  output logic                        ready_o,
  output logic [NUM_LANES-1:0]        served_o,
  output logic [NUM_LANES*BANK_W-1:0] bank_idx_o,
  output logic [NUM_LANES*OFF_W-1:0]  bank_off_o,
  output logic                        last_o
);
  logic [NUM_LANES*BANK_W-1:0] map_bank;
  logic [NUM_LANES*OFF_W-1:0]  map_off;
  logic [NUM_LANES-1:0]        pending, still;
  logic                        sel_store;

  bank_addr_map #(
    .NUM_LANES(NUM_LANES), .NUM_BANKS(NUM_BANKS),
    .BANK_DEPTH(BANK_DEPTH), .WORD_BYTES(WORD_BYTES)
  ) u_map (
    .addr_i(addr_i), .bank_o(map_bank), .off_o(map_off)
  );

  bank_issue_ctrl #(
    .NUM_LANES(NUM_LANES), .BANK_W(BANK_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .store_i(store_i),
    .mask_i(lane_mask_i), .bank_i(map_bank), .off_i(map_off), .still_i(still),
    .pending_o(pending), .bank_o(bank_idx_o), .off_o(bank_off_o),
    .store_o(sel_store), .ready_o(ready_o), .last_o(last_o)
  );

  bank_conflict_logic #(
    .NUM_LANES(NUM_LANES), .NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH)
  ) u_conf (
    .clk_i(clk_i), .rst_ni(rst_ni), .pending_i(pending), .bank_i(bank_idx_o),
    .off_i(bank_off_o), .store_i(sel_store), .served_o(served_o), .still_o(still)
  );
endmodule

// File: tb/sim_bank_serializer.sv
module sim_bank_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 4;
  localparam int BW = 2;
  localparam int OW = 6;
  localparam int AW = 10;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic            store_i = 1'b0;
  logic [L-1:0]    lane_mask_i = '0;
  logic [L*AW-1:0] addr_i = '0;
  logic            ready_o, last_o;
  logic [L-1:0]    served_o;
  logic [L*BW-1:0] bank_idx_o;
  logic [L*OW-1:0] bank_off_o;

  int checks = 0;
  int errors = 0;
  int b_a[L];
  int o_a[L];

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_serializer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .store_i(store_i),
    .lane_mask_i(lane_mask_i), .addr_i(addr_i), .ready_o(ready_o),
    .served_o(served_o), .bank_idx_o(bank_idx_o), .bank_off_o(bank_off_o),
    .last_o(last_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // lanes served from pending mask p, derived from R3/R4/R5
  function automatic logic [L-1:0] step_mask(logic [L-1:0] p, logic st);
    logic [L-1:0] r = '0;
    int top = -1;
    for (int k = 0; k < L; k++) if (p[k] && top < 0) top = k;
    for (int j = 0; j < L; j++) begin
      if (p[j]) begin
        if (!st && b_a[j] == b_a[top] && o_a[j] == o_a[top]) r[j] = 1'b1;
        else begin
          bit taken = 0;
          for (int i = 0; i < j; i++) if (p[i] && b_a[i] == b_a[j]) taken = 1;
          r[j] = !taken;
        end
      end
    end
    return r;
  endfunction

  // called at a negedge; returns at the negedge after the final cycle
  task automatic run_request(input logic [L-1:0] m, input logic st, output int cyc);
    logic [L-1:0] pend, exp_s, rem;
    logic [L*AW-1:0] a;
    logic [L*BW-1:0] eb;
    logic [L*OW-1:0] eo;
    for (int k = 0; k < L; k++) begin
      a[k*AW +: AW] = AW'(o_a[k]*16 + b_a[k]*4 + (k % 4));
      eb[k*BW +: BW] = BW'(b_a[k]);
      eo[k*OW +: OW] = OW'(o_a[k]);
    end
    start_i = 1'b1; store_i = st; lane_mask_i = m; addr_i = a;
    pend = m;
    cyc = 0;
    forever begin
      #(CLK_PERIOD/4);
      exp_s = step_mask(pend, st);
      rem = pend & ~exp_s;
      chk(served_o == exp_s, "R3 served", 32'(served_o), 32'(exp_s));
      chk(last_o == ((rem == '0) && (pend != '0)), "R8 last", 32'(last_o), 32'((rem == '0) && (pend != '0)));
      chk(ready_o == (cyc == 0), cyc == 0 ? "R9 ready" : "R6 ready", 32'(ready_o), 32'(cyc == 0));
      if (m != '0)
        chk(bank_idx_o == eb && bank_off_o == eo, cyc == 0 ? "R1 fields" : "R6 replay",
            {bank_idx_o, bank_off_o}, {eb, eo});
      cyc++;
      @(negedge clk);
      if (rem == '0) break;
      // garbage while busy must be ignored
      start_i = 1'b1; store_i = ~st; lane_mask_i = ~m; addr_i = ~a;
      pend = rem;
    end
    start_i = 1'b0;
  endtask

  initial begin
    int cyc;
    #(CLK_PERIOD/4);
    chk(ready_o == 1'b1 && served_o == '0 && last_o == 1'b0, "R10 in reset",
        {ready_o, served_o, last_o}, 32'h20);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #(CLK_PERIOD/4);
    chk(ready_o == 1'b1 && served_o == '0 && last_o == 1'b0, "R10 after reset",
        {ready_o, served_o, last_o}, 32'h20);
    @(negedge clk);

    // R2: start low with a clashing mask does nothing
    for (int k = 0; k < L; k++) begin b_a[k] = 1; o_a[k] = k; end
    start_i = 1'b0; lane_mask_i = '1;
    for (int k = 0; k < L; k++) addr_i[k*AW +: AW] = AW'(k*16 + 4);
    #(CLK_PERIOD/4);
    chk(served_o == '0 && last_o == 1'b0 && ready_o == 1'b1, "R2 start low",
        {ready_o, served_o, last_o}, 32'h20);
    @(negedge clk);
    #(CLK_PERIOD/4);
    chk(ready_o == 1'b1, "R2 still ready", 32'(ready_o), 32'd1);
    @(negedge clk);

    // R7: four lanes, one bank, four words
    run_request(4'hF, 1'b0, cyc);
    chk(cyc == 4, "R7 cycles", 32'(cyc), 32'd4);
    // R4: four reads of one word merge
    for (int k = 0; k < L; k++) begin b_a[k] = 2; o_a[k] = 37; end
    run_request(4'hF, 1'b0, cyc);
    chk(cyc == 1, "R4 broadcast", 32'(cyc), 32'd1);
    // R5: four stores of one word never merge
    run_request(4'hF, 1'b1, cyc);
    chk(cyc == 4, "R5 store serial", 32'(cyc), 32'd4);
    // R2: zero mask
    run_request(4'h0, 1'b0, cyc);
    chk(cyc == 1, "R2 zero mask", 32'(cyc), 32'd1);

    // sweep of all bank patterns, masks and ops
    for (int bp = 0; bp < 256; bp++) begin
      for (int v = 0; v < 2; v++) begin
        for (int k = 0; k < L; k++) begin
          b_a[k] = (bp >> (2*k)) & 3;
          o_a[k] = (v == 0) ? 0 : ((k % 2 == 1) ? 63 : 5);
        end
        for (int m = 0; m < 16; m++)
          for (int st = 0; st < 2; st++)
            run_request(4'(m), 1'(st), cyc);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule